// File: doc/BRIEF.md
# Switch-Matched Bus Address Decoder

This block sits behind a 32-bit host bus on a serial link test board. Each request carries a word-aligned byte address. The block compares that address against base values set on switches. It sends the access either to one of the board's two 16K-word memories or to a small register window. If the address matches neither, nothing happens.

Each region has its own switch base for address bits 23-17. Each region also has a second base for bits 31-24, and an enable that decides whether those upper bits take part in the match.

Inside the memory window, bit 16 chooses the transmit or the receive memory, and bits 15-2 give the word index. Inside the register window, the block holds a write-only 9-bit control word. It also returns one of three 16-bit status words that the surrounding logic supplies. All results come from registers and appear one clock after the request.

Top module: `sdec_bus_decoder`

## Requirements
- R1: A region is hit when address bits 23-17 equal its 7-bit low base. When that region's upper enable input is 1, address bits 31-24 must also equal its 8-bit high base. When the enable is 0, bits 31-24 are ignored. A base bit of 1 (switch up) requires a 1 on the matching address bit.
- R2: A request that hits neither region raises no select and no acknowledge, and it leaves the control word unchanged.
- R3: For a memory hit, `mem_is_tx` equals address bit 16: 0 selects the receive memory and 1 selects the transmit memory.
- R4: For a memory hit, `mem_index` equals address bits 15-2. Address bits 1-0 never affect any result.
- R5: A write hitting the register window with address bits 16-2 all zero loads `bus_wdata[8:0]` into the control word. The control word leaves reset at 0x08F. Its bit meanings are: bit 8 run enable, bit 7 idle-character select, bit 4 word-sync enable, bits 3-0 active-low reset lines.
- R6: A read of register offset 0 is acknowledged and returns zero.
- R7: A read at register byte offset 0x20, 0x24 or 0x28 returns `status_a`, `status_b` or `status_c` in bits 15-0, with bits 31-16 zero. Any other register offset reads zero.
- R8: A write to any register offset other than 0 is acknowledged and changes nothing.
- R9: `ack`, `mem_sel`, `reg_sel`, `mem_is_tx`, `mem_index` and `rdata` are registered. They reflect the request presented in the previous cycle, and a new request may be presented on every cycle. With no request, `ack` is 0 in the following cycle.
- R10: When both regions are hit, the memory region wins and the register window sees nothing.
- R11: An acknowledged memory access returns zero on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| mem_base_lo | input | 7 | Memory base for address bits 23-17 |
| mem_base_hi | input | 8 | Memory base for address bits 31-24 |
| mem_hi_en | input | 1 | Include bits 31-24 in memory match |
| reg_base_lo | input | 7 | Register base for address bits 23-17 |
| reg_base_hi | input | 8 | Register base for address bits 31-24 |
| reg_hi_en | input | 1 | Include bits 31-24 in register match |
| status_a | input | 16 | Status word at offset 0x20 |
| status_b | input | 16 | Status word at offset 0x24 |
| status_c | input | 16 | Status word at offset 0x28 |
| ack | output | 1 | Request accepted (previous cycle) |
| mem_sel | output | 1 | Memory access accepted |
| reg_sel | output | 1 | Register access accepted |
| mem_is_tx | output | 1 | 1 = transmit memory, 0 = receive memory |
| mem_index | output | 14 | Memory word index |
| rdata | output | 32 | Register read data |
| ctrl_q | output | 9 | Control word |

## Verification
Every decode result, including `ack`, the selects, the bank bit, the index and the read data, is due exactly one clock edge after the request is presented. A control write shows on `ctrl_q` after that same edge.

The driver presents a request on a falling edge. It queues the expected outcome tagged with the number of the next rising edge. The monitor compares the outcome on the falling edge after that rising edge, so no check depends on the order of processes at an edge. Idle cycles are queued as well, which lets the monitor confirm that `ack` stays low and that back-to-back requests are not merged.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int LO_MSB    = 23;
  localparam int LO_LSB    = 17;
  localparam int LO_W      = LO_MSB - LO_LSB + 1;
  localparam int HI_W      = ADDR_W - 1 - LO_MSB;
  localparam int BANK_BIT  = 16;
  localparam int IDX_W     = BANK_BIT - 2;
  localparam int OFS_W     = BANK_BIT - 1;
  localparam int CTRL_W    = 9;
  localparam int STAT_W    = 16;
  localparam int NUM_STAT  = 3;
  localparam int STAT_WOFS = 8;               // byte offset 0x20 as word offset
  localparam logic [CTRL_W-1:0] CTRL_RST = 9'h08F;

  typedef enum logic [0:0] { RGN_MEM = 1'b0, RGN_REG = 1'b1 } region_e;

  function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                      input logic [LO_W-1:0]   lo,
                                      input logic [HI_W-1:0]   hi,
                                      input logic              hi_en);
    return (a[LO_MSB:LO_LSB] == lo) && (!hi_en || (a[ADDR_W-1:LO_MSB+1] == hi));
  endfunction

  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return a[BANK_BIT-1:2];
  endfunction

  function automatic logic [OFS_W-1:0] reg_offset(input logic [ADDR_W-1:0] a);
    return a[BANK_BIT:2];
  endfunction
endpackage

// File: rtl/sdec_region_match.sv
module sdec_region_match
  import sdec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [LO_W-1:0]   base_lo,
  input  logic [HI_W-1:0]   base_hi,
  input  logic              hi_en,
  output logic              hit
);
  assign hit = region_hit(addr, base_lo, base_hi, hi_en);
endmodule

// File: rtl/sdec_stat_mux.sv
module sdec_stat_mux
  import sdec_pkg::*;
(
  input  logic [OFS_W-1:0]                 ofs,
  input  logic [NUM_STAT-1:0][STAT_W-1:0]  words,
  output logic [NUM_STAT-1:0]              pick,
  output logic [STAT_W-1:0]                rd
);
  for (genvar g = 0; g < NUM_STAT; g++) begin : g_pick
    assign pick[g] = (ofs == OFS_W'(STAT_WOFS + g));
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < NUM_STAT; i++) begin
      if (pick[i]) rd = rd | words[i];
    end
  end
endmodule

// File: rtl/sdec_ctrl_reg.sv
module sdec_ctrl_reg
  import sdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= CTRL_RST;
    else if (wr_en) q <= wr_data;
  end

  // R5: an accepted control write lands on the next edge
  a_r5_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(wr_data)));
  // R8: without a control write the word holds
  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/sdec_bus_decoder.sv
module sdec_bus_decoder
  import sdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [6:0]        mem_base_lo,
  input  logic [7:0]        mem_base_hi,
  input  logic              mem_hi_en,
  input  logic [6:0]        reg_base_lo,
  input  logic [7:0]        reg_base_hi,
  input  logic              reg_hi_en,
  input  logic [15:0]       status_a,
  input  logic [15:0]       status_b,
  input  logic [15:0]       status_c,
  output logic              ack,
  output logic              mem_sel,
  output logic              reg_sel,
  output logic              mem_is_tx,
  output logic [13:0]       mem_index,
  output logic [31:0]       rdata,
  output logic [8:0]        ctrl_q
);
  // region comparators, one per window
  logic [1:0][LO_W-1:0] base_lo_arr;
  logic [1:0][HI_W-1:0] base_hi_arr;
  logic [1:0]           hi_en_arr;
  logic [1:0]           hit_arr;

  assign base_lo_arr[RGN_MEM] = mem_base_lo;
  assign base_lo_arr[RGN_REG] = reg_base_lo;
  assign base_hi_arr[RGN_MEM] = mem_base_hi;
  assign base_hi_arr[RGN_REG] = reg_base_hi;
  assign hi_en_arr[RGN_MEM]   = mem_hi_en;
  assign hi_en_arr[RGN_REG]   = reg_hi_en;

  for (genvar r = 0; r < 2; r++) begin : g_rgn
    sdec_region_match i_match (
      .addr    (bus_addr),
      .base_lo (base_lo_arr[r]),
      .base_hi (base_hi_arr[r]),
      .hi_en   (hi_en_arr[r]),
      .hit     (hit_arr[r])
    );
  end

  // named decode events
  logic             take_mem, take_reg, ctrl_wr_evt;
  logic [OFS_W-1:0] ofs;
  assign take_mem    = bus_valid && hit_arr[RGN_MEM];
  assign take_reg    = bus_valid && hit_arr[RGN_REG] && !hit_arr[RGN_MEM];
  assign ofs         = reg_offset(bus_addr);
  assign ctrl_wr_evt = take_reg && bus_write && (ofs == '0);

  // status read path
  logic [NUM_STAT-1:0][STAT_W-1:0] stat_words;
  logic [NUM_STAT-1:0]             stat_pick;
  logic [STAT_W-1:0]               stat_rd;
  assign stat_words[0] = status_a;
  assign stat_words[1] = status_b;
  assign stat_words[2] = status_c;

  sdec_stat_mux i_stat (
    .ofs   (ofs),
    .words (stat_words),
    .pick  (stat_pick),
    .rd    (stat_rd)
  );

  logic [DATA_W-1:0] rd_next;
  assign rd_next = (take_reg && !bus_write) ? {{(DATA_W-STAT_W){1'b0}}, stat_rd} : '0;

  sdec_ctrl_reg i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctrl_wr_evt),
    .wr_data (bus_wdata[CTRL_W-1:0]),
    .q       (ctrl_q)
  );

  // result stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      mem_sel   <= 1'b0;
      reg_sel   <= 1'b0;
      mem_is_tx <= 1'b0;
      mem_index <= '0;
      rdata     <= '0;
    end else begin
      ack     <= take_mem || take_reg;
      mem_sel <= take_mem;
      reg_sel <= take_reg;
      rdata   <= rd_next;
      if (take_mem) begin
        mem_is_tx <= bus_addr[BANK_BIT];
        mem_index <= word_index(bus_addr);
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DATA_W-1:CTRL_W], bus_addr[1:0]};

  // R10: a request never reaches both windows
  a_r10_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_sel && reg_sel));
  // R2, R9: no request, no acknowledge next cycle
  a_r2_no_req_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !ack);
  // R3: bank bit follows address bit 16 of the accepted request
  a_r3_bank: assert property (@(posedge clk) disable iff (!rst_n)
    take_mem |=> (mem_sel && mem_is_tx == $past(bus_addr[BANK_BIT])));
  // R4: word index follows address bits 15-2
  a_r4_index: assert property (@(posedge clk) disable iff (!rst_n)
    take_mem |=> (mem_index == $past(bus_addr[BANK_BIT-1:2])));
  // R7: upper half of read data is always zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (rdata[DATA_W-1:STAT_W] == '0));
  // R7: at most one status word is picked
  a_r7_stat_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_pick));
endmodule

// File: tb/test_sdec_bus_decoder.sv
module test_sdec_bus_decoder;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        bus_valid = 0, bus_write = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic [6:0]  mem_base_lo = 7'h40, reg_base_lo = 7'h48;
  logic [7:0]  mem_base_hi = 8'hFA, reg_base_hi = 8'hFA;
  logic        mem_hi_en = 0, reg_hi_en = 0;
  logic [15:0] status_a = 16'hA5C3, status_b = 16'h1E27, status_c = 16'h0911;
  logic        ack, mem_sel, reg_sel, mem_is_tx;
  logic [13:0] mem_index;
  logic [31:0] rdata;
  logic [8:0]  ctrl_q;

  sdec_bus_decoder i_sdec_bus_decoder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mem_base_lo(mem_base_lo), .mem_base_hi(mem_base_hi), .mem_hi_en(mem_hi_en),
    .reg_base_lo(reg_base_lo), .reg_base_hi(reg_base_hi), .reg_hi_en(reg_hi_en),
    .status_a(status_a), .status_b(status_b), .status_c(status_c),
    .ack(ack), .mem_sel(mem_sel), .reg_sel(reg_sel), .mem_is_tx(mem_is_tx),
    .mem_index(mem_index), .rdata(rdata), .ctrl_q(ctrl_q)
  );

  typedef struct {
    int          due;
    bit          ack, ms, rs, tx;
    logic [13:0] idx;
    logic [31:0] rd;
    logic [8:0]  ctl;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   checks = 0, errors = 0;
  logic [8:0] exp_ctrl = 9'h08F;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit bhit(input logic [31:0] a, input logic [6:0] lo,
                              input logic [7:0] hi, input bit en);
    logic [31:0] m;
    m = en ? 32'hFFFE_0000 : 32'h00FE_0000;
    return ((a ^ {hi, lo, 17'd0}) & m) == 32'd0;
  endfunction

  // driver: present one request and queue its expected outcome
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input string tag);
    exp_t e;
    bit hm, hr;
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = wd;
    hm = bhit(a, mem_base_lo, mem_base_hi, mem_hi_en);
    hr = bhit(a, reg_base_lo, reg_base_hi, reg_hi_en) && !hm;
    e.due = cyc + 1; e.tag = tag;
    e.ms = hm; e.rs = hr; e.ack = hm || hr;
    e.tx = a[16]; e.idx = a[15:2]; e.rd = 32'd0;
    if (hr && !wr) begin
      case ({a[16:2], 2'b00})
        17'h00020: e.rd = {16'd0, status_a};
        17'h00024: e.rd = {16'd0, status_b};
        17'h00028: e.rd = {16'd0, status_c};
        default:   e.rd = 32'd0;
      endcase
    end
    if (hr && wr && a[16:2] == 15'd0) exp_ctrl = wd[8:0];
    e.ctl = exp_ctrl;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    e.due = cyc + 1; e.tag = tag;
    e.ack = 0; e.ms = 0; e.rs = 0; e.tx = 0; e.idx = '0; e.rd = '0;
    e.ctl = exp_ctrl;
    sb.push_back(e);
  endtask

  // monitor: compare on the falling edge after the due rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk(ack == e.ack, e.tag, "ack", 32'(ack), 32'(e.ack));
        chk(mem_sel == e.ms && reg_sel == e.rs, e.tag, "sel",
            {30'd0, mem_sel, reg_sel}, {30'd0, e.ms, e.rs});
        chk(ctrl_q == e.ctl, e.tag, "ctrl", 32'(ctrl_q), 32'(e.ctl));
        if (e.ms) begin
          chk(mem_is_tx == e.tx, e.tag, "bank", 32'(mem_is_tx), 32'(e.tx));
          chk(mem_index == e.idx, e.tag, "index", 32'(mem_index), 32'(e.idx));
        end
        if (e.ack) chk(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ack == 0, "R9", "reset ack", 32'(ack), 0);
    chk(ctrl_q == 9'h08F, "R5", "reset ctrl", 32'(ctrl_q), 32'h08F);

    // R1 upper bits ignored, R4 low bits ignored
    access(0, 32'h1280_7F05, 0, "R1_R4");
    access(0, 32'hFA81_0008, 0, "R3");
    access(1, 32'hFA80_0010, 32'h1FF, "R11");
    idle("R9");
    @(negedge clk); mem_hi_en = 1;
    access(0, 32'h1280_0000, 0, "R1");
    access(0, 32'hFA80_0004, 0, "R1");
    access(0, 32'h0000_0000, 0, "R2");
    access(1, 32'hFA90_0000, 32'hFFFF_F10F, "R5");
    access(0, 32'hFA90_0000, 0, "R6");
    access(0, 32'hFA90_0020, 0, "R7");
    access(0, 32'hFA90_0026, 0, "R7");
    access(0, 32'hFA90_0028, 0, "R7");
    access(0, 32'hFA90_0030, 0, "R7");
    access(1, 32'hFA90_0024, 32'h0, "R8");
    access(0, 32'hFA90_0024, 0, "R8");
    access(1, 32'hFA90_0003, 32'h080, "R5");
    @(negedge clk); reg_hi_en = 1;
    access(1, 32'h1290_0000, 32'h0, "R2");
    @(negedge clk); reg_base_lo = 7'h40; reg_hi_en = 0;
    access(1, 32'hFA80_0000, 32'h0, "R10");
    access(0, 32'hFA81_FFFC, 0, "R10");
    idle("R9");
    idle("R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule